// File: doc/BRIEF.md
# Endpoint-Zero Control Register with Write Interlock

This block is the 8-bit mode and status register of a USB device's default control endpoint. Two agents write it. The serial interface engine posts transaction events and can load a new endpoint mode. The CPU reads the register and writes it over a simple strobe bus. The register holds four sticky flags and a mode nibble. The flags are SETUP seen, IN acknowledged, OUT accepted and transaction acknowledged.

Whenever the engine changes the register, an interlock closes. The CPU cannot overwrite the freshly posted status until it has read the register. An accepted CPU write always wipes the flags, and its low nibble becomes the new mode. While a control transfer's SETUP data and write data phase are in progress, the SETUP flag cannot be cleared. For as long as that flag is set, the block gates off the CPU's write enable to the endpoint-zero data FIFO.

Top module: `ep0_ctl_reg`

## Requirements
- R1: After a synchronous reset, `rdata` reads 8'h00 and `locked` is 0.
- R2: Register layout: bit 7 is SETUP seen, bit 6 is IN acknowledged, bit 5 is OUT accepted, bit 4 is transaction acknowledged, bits 3:0 are the mode. Each of `ev_setup` (or `ev_setup_data_start`), `ev_in_acked`, `ev_out_acked` and `ev_ack_txn` sets its own bit on the next clock edge, and the bit stays set until an accepted CPU write.
- R3: Any engine update sets `locked` on the next edge. The engine updates are a flag event, `ev_setup_data_start` or `sie_mode_wr`. A CPU write while `locked` is 1 leaves `rdata` unchanged.
- R4: A `cpu_rd` strobe clears `locked` on the next edge, unless an engine update occurs in the same cycle. A write in the cycle after the read is accepted.
- R5: An accepted CPU write loads `cpu_wdata[3:0]` into the mode and clears bits 7:4, whatever `cpu_wdata[7:4]` holds.
- R6: If an engine update and a CPU write fall in the same cycle, the engine update takes effect and the CPU write is discarded entirely.
- R7: After `ev_setup_data_start` and until `ev_ctrl_wr_data_end`, an accepted write does not clear bit 7. It still clears bits 6:4 and loads the mode. `ev_ctrl_wr_data_end` does not lock the register.
- R8: `fifo_wr_en` follows `cpu_fifo_we` in the same cycle while bit 7 is 0, and is 0 while bit 7 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_rd | input | 1 | CPU read strobe for the register |
| cpu_wr | input | 1 | CPU write strobe for the register |
| cpu_wdata | input | 8 | CPU write data; only bits 3:0 are used |
| cpu_fifo_we | input | 1 | CPU write request to the endpoint-zero FIFO |
| ev_setup | input | 1 | Valid SETUP packet received |
| ev_setup_data_start | input | 1 | Data packet of a SETUP transaction begins |
| ev_ctrl_wr_data_end | input | 1 | Data phase of a control write transfer ends |
| ev_in_acked | input | 1 | Host acknowledged an IN data packet |
| ev_out_acked | input | 1 | Last packet of an OUT transaction accepted with ACK |
| ev_ack_txn | input | 1 | Transaction to this endpoint completed with ACK |
| sie_mode_wr | input | 1 | Engine loads a new mode |
| sie_mode_data | input | 4 | Mode value from the engine |
| rdata | output | 8 | Register contents |
| locked | output | 1 | Interlock state; CPU writes are ignored while 1 |
| fifo_wr_en | output | 1 | Gated FIFO write enable |

## Verification
An engine update can fall in the same cycle as either of two CPU actions: a register write, or the read that would release the lock. The bench provokes both cases. In one step, an engine mode load coincides with a CPU write. In another, an IN-acknowledge event arrives together with a read. The bench judges the first by the engine's mode and a set lock. It judges the second by a lock that stays closed, which a CPU write in the following cycle then fails to get past.

// File: rtl/ep0_reg_pkg.sv
package ep0_reg_pkg;
  localparam int N_FLAGS   = 4;
  localparam int FLG_SETUP = 3;
  localparam int FLG_IN    = 2;
  localparam int FLG_OUT   = 1;
  localparam int FLG_ACK   = 0;
endpackage

// File: rtl/ep0_lock_ctl.sv
module ep0_lock_ctl (
  input  logic clk,
  input  logic rst,
  input  logic sie_upd,
  input  logic cpu_rd,
  input  logic cpu_wr,
  output logic lock_q,
  output logic wr_accept
);
  always_ff @(posedge clk) begin
    if (rst)          lock_q <= 1'b0;
    else if (sie_upd) lock_q <= 1'b1;
    else if (cpu_rd)  lock_q <= 1'b0;
  end

  // engine traffic in the same cycle discards the CPU write
  assign wr_accept = cpu_wr & ~lock_q & ~sie_upd;
endmodule

// File: rtl/ep0_setup_hold.sv
module ep0_setup_hold (
  input  logic clk,
  input  logic rst,
  input  logic win_open,
  input  logic win_close,
  output logic hold_q
);
  always_ff @(posedge clk) begin
    if (rst)            hold_q <= 1'b0;
    else if (win_open)  hold_q <= 1'b1;
    else if (win_close) hold_q <= 1'b0;
  end
endmodule

// File: rtl/ep0_flag_bank.sv
module ep0_flag_bank #(
  parameter int N_FLAGS  = 4,
  parameter int HOLD_IDX = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_FLAGS-1:0] set_vec,
  input  logic               clr,
  input  logic               hold,
  output logic [N_FLAGS-1:0] flags_q
);
  for (genvar i = 0; i < N_FLAGS; i++) begin : g_flag
    if (i == HOLD_IDX) begin : g_held
      always_ff @(posedge clk) begin
        if (rst)             flags_q[i] <= 1'b0;
        else if (set_vec[i]) flags_q[i] <= 1'b1;
        else if (clr && !hold) flags_q[i] <= 1'b0;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst)             flags_q[i] <= 1'b0;
        else if (set_vec[i]) flags_q[i] <= 1'b1;
        else if (clr)        flags_q[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ep0_ctl_reg.sv
module ep0_ctl_reg
  import ep0_reg_pkg::*;
#(
  parameter int MODE_W = 4,
  localparam int REG_W = N_FLAGS + MODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [REG_W-1:0]  cpu_wdata,
  input  logic              cpu_fifo_we,
  input  logic              ev_setup,
  input  logic              ev_setup_data_start,
  input  logic              ev_ctrl_wr_data_end,
  input  logic              ev_in_acked,
  input  logic              ev_out_acked,
  input  logic              ev_ack_txn,
  input  logic              sie_mode_wr,
  input  logic [MODE_W-1:0] sie_mode_data,
  output logic [REG_W-1:0]  rdata,
  output logic              locked,
  output logic              fifo_wr_en
);
  logic [N_FLAGS-1:0] set_vec;
  logic [N_FLAGS-1:0] flags_q;
  logic [MODE_W-1:0]  mode_q;
  logic               sie_upd;
  logic               wr_accept;
  logic               hold_q;
  logic               unused_wdata_hi;

  assign unused_wdata_hi = ^cpu_wdata[REG_W-1:MODE_W];

  always_comb begin
    set_vec            = '0;
    set_vec[FLG_SETUP] = ev_setup | ev_setup_data_start;
    set_vec[FLG_IN]    = ev_in_acked;
    set_vec[FLG_OUT]   = ev_out_acked;
    set_vec[FLG_ACK]   = ev_ack_txn;
  end

  assign sie_upd = (|set_vec) | sie_mode_wr;

  ep0_lock_ctl u_lock (
    .clk      (clk),
    .rst      (rst),
    .sie_upd  (sie_upd),
    .cpu_rd   (cpu_rd),
    .cpu_wr   (cpu_wr),
    .lock_q   (locked),
    .wr_accept(wr_accept)
  );

  ep0_setup_hold u_hold (
    .clk      (clk),
    .rst      (rst),
    .win_open (ev_setup_data_start),
    .win_close(ev_ctrl_wr_data_end),
    .hold_q   (hold_q)
  );

  ep0_flag_bank #(
    .N_FLAGS (N_FLAGS),
    .HOLD_IDX(FLG_SETUP)
  ) u_flags (
    .clk    (clk),
    .rst    (rst),
    .set_vec(set_vec),
    .clr    (wr_accept),
    .hold   (hold_q),
    .flags_q(flags_q)
  );

  always_ff @(posedge clk) begin
    if (rst)              mode_q <= '0;
    else if (sie_mode_wr) mode_q <= sie_mode_data;
    else if (wr_accept)   mode_q <= cpu_wdata[MODE_W-1:0];
  end

  assign rdata      = {flags_q, mode_q};
  assign fifo_wr_en = cpu_fifo_we & ~flags_q[FLG_SETUP];
endmodule

// File: rtl/ep0_ctl_reg_chk.sv
module ep0_ctl_reg_chk #(
  parameter int MODE_W = 4,
  localparam int REG_W = 4 + MODE_W
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_rd,
  input logic              cpu_wr,
  input logic [REG_W-1:0]  cpu_wdata,
  input logic              ev_setup,
  input logic              ev_setup_data_start,
  input logic              ev_in_acked,
  input logic              ev_out_acked,
  input logic              ev_ack_txn,
  input logic              sie_mode_wr,
  input logic [MODE_W-1:0] sie_mode_data,
  input logic [REG_W-1:0]  rdata,
  input logic              locked,
  input logic              fifo_wr_en
);
  logic upd;
  assign upd = ev_setup | ev_setup_data_start | ev_in_acked | ev_out_acked |
               ev_ack_txn | sie_mode_wr;

  // R1
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (rdata == '0) && !locked);

  // R3
  a_r3_lock_on_update: assert property (@(posedge clk) disable iff (rst)
    upd |=> locked);

  // R3
  a_r3_locked_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (locked && cpu_wr && !upd) |=> $stable(rdata));

  // R4
  a_r4_read_unlocks: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && !upd) |=> !locked);

  // R5
  a_r5_write_effect: assert property (@(posedge clk) disable iff (rst)
    (!locked && cpu_wr && !upd) |=>
      (rdata[MODE_W-1:0] == $past(cpu_wdata[MODE_W-1:0])) &&
      (rdata[REG_W-2:MODE_W] == '0));

  // R6
  a_r6_engine_wins: assert property (@(posedge clk) disable iff (rst)
    (sie_mode_wr && cpu_wr) |=> (rdata[MODE_W-1:0] == $past(sie_mode_data)) && locked);

  // R7
  a_r7_setup_start_sets: assert property (@(posedge clk) disable iff (rst)
    ev_setup_data_start |=> rdata[REG_W-1]);

  // R8
  a_r8_fifo_gated: assert property (@(posedge clk) disable iff (rst)
    rdata[REG_W-1] |-> !fifo_wr_en);
endmodule

bind ep0_ctl_reg ep0_ctl_reg_chk #(.MODE_W(MODE_W)) u_chk (.*);

// File: tb/ep0_ctl_reg_bench.sv
`timescale 1ns/100ps
module ep0_ctl_reg_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cpu_rd = 0, cpu_wr = 0, cpu_fifo_we = 0;
  logic [7:0] cpu_wdata = '0;
  logic       ev_setup = 0, ev_setup_data_start = 0, ev_ctrl_wr_data_end = 0;
  logic       ev_in_acked = 0, ev_out_acked = 0, ev_ack_txn = 0, sie_mode_wr = 0;
  logic [3:0] sie_mode_data = '0;
  logic [7:0] rdata;
  logic       locked, fifo_wr_en;

  int checks = 0;
  int failures = 0;
  logic [8:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  ep0_ctl_reg u_ep0_ctl_reg (.*);

  // Monitor: compare registered outputs against queued expectations
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [8:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if ({rdata, locked} !== e) begin
        failures++;
        $display("FAIL %s: rdata=%h locked=%b expected rdata=%h locked=%b",
                 t, rdata, locked, e[8:1], e[0]);
      end
    end
  end

  // Driver: stimulus bits {setup, dstart, dend, in, out, ack}
  task automatic step(input string tag, input logic rd, input logic wr,
                      input logic [7:0] wd, input logic [5:0] ev,
                      input logic mw, input logic [3:0] md,
                      input logic [7:0] exp_d, input logic exp_l);
    cpu_rd = rd; cpu_wr = wr; cpu_wdata = wd;
    {ev_setup, ev_setup_data_start, ev_ctrl_wr_data_end,
     ev_in_acked, ev_out_acked, ev_ack_txn} = ev;
    sie_mode_wr = mw; sie_mode_data = md;
    @(posedge clk);
    exp_q.push_back({exp_d, exp_l});
    tag_q.push_back(tag);
    @(negedge clk);
    cpu_rd = 0; cpu_wr = 0; cpu_wdata = '0;
    {ev_setup, ev_setup_data_start, ev_ctrl_wr_data_end,
     ev_in_acked, ev_out_acked, ev_ack_txn} = '0;
    sie_mode_wr = 0;
  endtask

  task automatic fifo_check(input string tag, input logic exp);
    cpu_fifo_we = 1'b1;
    #1;
    checks++;
    if (fifo_wr_en !== exp) begin
      failures++;
      $display("FAIL %s: fifo_wr_en=%b expected %b", tag, fifo_wr_en, exp);
    end
    cpu_fifo_we = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    checks++;
    if (rdata !== 8'h00 || locked !== 1'b0) begin
      failures++;
      $display("FAIL R1: rdata=%h locked=%b expected 00/0", rdata, locked);
    end
    step("R5 write clears flags",        0,1,8'hF5,6'b000000,0,4'h0, 8'h05,0);
    step("R2 IN bit6 and R3 lock",       0,0,8'h00,6'b000100,0,4'h0, 8'h45,1);
    step("R3 locked write ignored",      0,1,8'h0A,6'b000000,0,4'h0, 8'h45,1);
    step("R4 read unlocks",              1,0,8'h00,6'b000000,0,4'h0, 8'h45,0);
    step("R4 write after read",          0,1,8'hF3,6'b000000,0,4'h0, 8'h03,0);
    step("R2 OUT bit5 ACK bit4",         0,0,8'h00,6'b000011,0,4'h0, 8'h33,1);
    step("R4 read",                      1,0,8'h00,6'b000000,0,4'h0, 8'h33,0);
    step("R6 engine mode beats write",   0,1,8'h02,6'b000000,1,4'h9, 8'h39,1);
    step("R4 read",                      1,0,8'h00,6'b000000,0,4'h0, 8'h39,0);
    step("R2 SETUP bit7",                0,0,8'h00,6'b100000,0,4'h0, 8'hB9,1);
    fifo_check("R8 fifo blocked by SETUP", 1'b0);
    step("R4 read",                      1,0,8'h00,6'b000000,0,4'h0, 8'hB9,0);
    step("R5 clears SETUP outside hold", 0,1,8'h01,6'b000000,0,4'h0, 8'h01,0);
    fifo_check("R8 fifo passes", 1'b1);
    step("R7 data start sets SETUP",     0,0,8'h00,6'b010000,0,4'h0, 8'h81,1);
    step("R2 ACK while held",            0,0,8'h00,6'b000001,0,4'h0, 8'h91,1);
    step("R4 read",                      1,0,8'h00,6'b000000,0,4'h0, 8'h91,0);
    step("R7 SETUP kept in window",      0,1,8'hF4,6'b000000,0,4'h0, 8'h84,0);
    step("R7 window end does not lock",  0,0,8'h00,6'b001000,0,4'h0, 8'h84,0);
    step("R7 SETUP clears after window", 0,1,8'h06,6'b000000,0,4'h0, 8'h06,0);
    step("R4 read with engine event",    1,0,8'h00,6'b000100,0,4'h0, 8'h46,1);
    step("R3 write still locked",        0,1,8'h00,6'b000000,0,4'h0, 8'h46,1);
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #50000;
    failures++;
    $display("FAIL watchdog: run did not complete, expected finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule